// File: doc/BRIEF.md
# Single-Port Synchronous RAM with Registered Inputs

This block is a single-port random access memory made of a storage array placed behind a rank of input registers. Chip select, write enable, address and write data are all captured on the rising clock edge. The captured pair of controls marks the following clock cycle as idle, a read or a write. The read path has no output register. Read data comes straight from the array through the captured address, so the output tracks the array contents for the whole cycle. The word count and word width are parameters. The word count may be any multiple of four from 8 to 256, and the width may be 1 to 32 bits.

A write cycle puts the word being written on the data output. An idle cycle drives the output explicitly invalid: `valid_o` is low and the data bus is zero, so nothing from an earlier cycle is held. When the word count is not a power of two, some address codes have no word behind them. Such a code is reported on `addr_err_o` and never writes. A test-only enable input is not registered and gates the array directly. It must be high in normal use. The storage array has no reset; the reset clears only the input registers, which then hold an idle cycle.

Top module: `sp_sync_ram`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, the block is idle: `valid_o` and `addr_err_o` are 0 and `rdata_o` is 0.
- R2: `cs_ni`, `we_ni`, `addr_i` and `wdata_i` affect the outputs only through their values at a rising clock edge. Changing them between edges leaves `rdata_o`, `valid_o` and `addr_err_o` unchanged.
- R3: When `cs_ni` is sampled high, the next cycle is idle: `valid_o`=0, `addr_err_o`=0, `rdata_o`=0. Nothing is written, whatever `we_ni` was.
- R4: When `cs_ni`=0 and `we_ni`=0 are sampled with an in-range address and `force_en_i` is high, the next cycle shows the sampled write data on `rdata_o` with `valid_o`=1. The array holds that word at that address from the end of that cycle.
- R5: When `cs_ni`=0 and `we_ni`=1 are sampled with an in-range address and `force_en_i` is high, the next cycle shows the stored word at that address on `rdata_o` with `valid_o`=1.
- R6: When `cs_ni`=0 is sampled with an address >= DEPTH, the next cycle has `addr_err_o`=1, `valid_o`=0 and `rdata_o`=0, and no word of the array changes.
- R7: `force_en_i` is not sampled. While it is low, `valid_o`=0 and `rdata_o`=0 in the same cycle, and a write cycle ending while it is low does not change the array.
- R8: A write followed in the next cycle by a read of the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; inputs captured on rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset of the input registers |
| cs_ni | input | 1 | Active-low chip select |
| we_ni | input | 1 | Active-low write enable (1 = read) |
| addr_i | input | $clog2(DEPTH) | Word address |
| wdata_i | input | WIDTH | Write data |
| force_en_i | input | 1 | Test-only array enable, unsampled; hold high in normal use |
| rdata_o | output | WIDTH | Read data, or the written word in a write cycle; 0 when invalid |
| valid_o | output | 1 | `rdata_o` carries a meaningful word this cycle |
| addr_err_o | output | 1 | Captured address lies beyond the configured depth |

## Verification
The assertions assume that the inputs change only away from the rising edge. They also assume that `force_en_i` is steady across each edge, so the value sampled at an edge is the value seen during the cycle that follows it. The stimulus changes every input, including the test enable, on the falling edge, and holds `rst_ni` low with chip select inactive so that no access is captured during reset. Reads only target addresses the bench has already written, because the array has no reset value. The default depth of 100 words leaves codes 100 to 127 unbacked, so both out-of-range reads and out-of-range writes are driven.

// File: rtl/sp_ram_pkg.sv
package sp_ram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } ram_op_e;
endpackage

// File: rtl/sp_ram_in_reg.sv
module sp_ram_in_reg #(
  parameter int AW = 7,
  parameter int W  = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic          cs_nq_o,
  output logic          we_nq_o,
  output logic [AW-1:0] addr_q_o,
  output logic [W-1:0]  data_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_nq_o  <= 1'b1;
      we_nq_o  <= 1'b1;
      addr_q_o <= '0;
      data_q_o <= '0;
    end else begin
      cs_nq_o  <= cs_ni;
      we_nq_o  <= we_ni;
      addr_q_o <= addr_i;
      data_q_o <= wdata_i;
    end
  end
endmodule

// File: rtl/sp_ram_array.sv
module sp_ram_array #(
  parameter int DEPTH = 100,
  parameter int W     = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [W-1:0]  rd_data_o
);
  localparam bit POW2 = ((1 << AW) == DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] idx;

  generate
    if (POW2) begin : g_full
      assign idx = addr_i;
    end else begin : g_clamp
      // unbacked codes fold to word 0; caller masks the result
      assign idx = ({1'b0, addr_i} < (AW+1)'(DEPTH)) ? addr_i : '0;
    end
  endgenerate

  // write lands at the edge that closes the write cycle
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[idx] <= wr_data_i;
  end

  assign rd_data_o = mem[idx];
endmodule

// File: rtl/sp_ram_ctrl.sv
module sp_ram_ctrl
  import sp_ram_pkg::*;
#(
  parameter int DEPTH = 100,
  parameter int W     = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          cs_nq_i,
  input  logic          we_nq_i,
  input  logic [AW-1:0] addr_q_i,
  input  logic [W-1:0]  data_q_i,
  input  logic          force_en_i,
  input  logic [W-1:0]  arr_rdata_i,
  output logic          mem_we_o,
  output logic [W-1:0]  rdata_o,
  output logic          valid_o,
  output logic          addr_err_o
);
  ram_op_e op;
  logic    in_range;

  always_comb begin
    if (cs_nq_i)      op = OP_IDLE;
    else if (we_nq_i) op = OP_READ;
    else              op = OP_WRITE;
  end

  assign in_range = ({1'b0, addr_q_i} < (AW+1)'(DEPTH));

  always_comb begin
    mem_we_o   = 1'b0;
    valid_o    = 1'b0;
    addr_err_o = 1'b0;
    rdata_o    = '0;
    case (op)
      OP_READ: begin
        addr_err_o = !in_range;
        valid_o    = in_range && force_en_i;
        if (valid_o) rdata_o = arr_rdata_i;
      end
      OP_WRITE: begin
        addr_err_o = !in_range;
        valid_o    = in_range && force_en_i;
        mem_we_o   = valid_o;
        if (valid_o) rdata_o = data_q_i;  // written word shown this cycle
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sp_sync_ram.sv
module sp_sync_ram #(
  parameter int DEPTH = 100,  // 8..256, multiple of 4
  parameter int WIDTH = 16,   // 1..32
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             we_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             force_en_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             valid_o,
  output logic             addr_err_o
);
  logic             cs_nq, we_nq, mem_we;
  logic [AW-1:0]    addr_q;
  logic [WIDTH-1:0] data_q, arr_rdata;

  sp_ram_in_reg #(.AW(AW), .W(WIDTH)) u_in_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .we_ni    (we_ni),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cs_nq_o  (cs_nq),
    .we_nq_o  (we_nq),
    .addr_q_o (addr_q),
    .data_q_o (data_q)
  );

  sp_ram_array #(.DEPTH(DEPTH), .W(WIDTH), .AW(AW)) u_array (
    .clk_i     (clk_i),
    .wr_en_i   (mem_we),
    .addr_i    (addr_q),
    .wr_data_i (data_q),
    .rd_data_o (arr_rdata)
  );

  sp_ram_ctrl #(.DEPTH(DEPTH), .W(WIDTH), .AW(AW)) u_ctrl (
    .cs_nq_i     (cs_nq),
    .we_nq_i     (we_nq),
    .addr_q_i    (addr_q),
    .data_q_i    (data_q),
    .force_en_i  (force_en_i),
    .arr_rdata_i (arr_rdata),
    .mem_we_o    (mem_we),
    .rdata_o     (rdata_o),
    .valid_o     (valid_o),
    .addr_err_o  (addr_err_o)
  );
endmodule

// File: rtl/sp_sync_ram_chk.sv
module sp_sync_ram_chk #(
  parameter int DEPTH = 100,
  parameter int WIDTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             we_ni,
  input logic [AW-1:0]    addr_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic             force_en_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic             valid_o,
  input logic             addr_err_o
);
  assert_idle_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> !valid_o && !addr_err_o);

  assert_deselect_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(cs_ni) |-> !valid_o && !addr_err_o && rdata_o == '0);

  assert_write_echo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(!cs_ni && !we_ni) && (32'($past(addr_i)) < DEPTH) && force_en_i
    |-> valid_o && rdata_o == $past(wdata_i));

  assert_range_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(!cs_ni) && (32'($past(addr_i)) >= DEPTH)
    |-> addr_err_o && !valid_o);

  assert_force_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_en_i |-> !valid_o && rdata_o == '0);

  assert_write_then_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(rst_ni, 2) && $past(!cs_ni && !we_ni, 2) && $past(!cs_ni && we_ni)
    && $past(addr_i) == $past(addr_i, 2) && (32'($past(addr_i)) < DEPTH)
    && $past(force_en_i) && force_en_i
    |-> rdata_o == $past(wdata_i, 2));
endmodule

bind sp_sync_ram sp_sync_ram_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/sp_sync_ram_tb_top.sv
`timescale 1ns/1ps
module sp_sync_ram_tb_top;
  localparam int DEPTH = 100;
  localparam int WIDTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cs_ni = 1'b1, we_ni = 1'b1, force_en_i = 1'b1;
  logic [AW-1:0]    addr_i = '0;
  logic [WIDTH-1:0] wdata_i = '0;
  logic [WIDTH-1:0] rdata_o;
  logic             valid_o, addr_err_o;

  int n_chk = 0, n_fail = 0;
  logic [WIDTH-1:0] ref_mem [int];
  bit               pend_wr = 0;
  int               pend_addr = 0;
  logic [WIDTH-1:0] pend_data = '0;

  always #5 clk_i = ~clk_i;

  sp_sync_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic step(input logic cs_n, input logic we_n, input int addr,
                      input logic [WIDTH-1:0] d, input logic fen, input string req);
    logic             e_valid, e_err;
    logic [WIDTH-1:0] e_data;
    bit               known;
    cs_ni = cs_n; we_ni = we_n; addr_i = AW'(addr); wdata_i = d; force_en_i = fen;
    @(posedge clk_i);
    if (pend_wr && fen) ref_mem[pend_addr] = pend_data;
    pend_wr = !cs_n && !we_n && addr < DEPTH;
    pend_addr = addr; pend_data = d;
    @(negedge clk_i);
    e_err   = !cs_n && addr >= DEPTH;
    e_valid = !cs_n && addr < DEPTH && fen;
    known   = 1;
    e_data  = '0;
    if (e_valid) begin
      if (!we_n) e_data = d;
      else if (ref_mem.exists(addr)) e_data = ref_mem[addr];
      else known = 0;
    end
    chk(valid_o === e_valid, req, 32'(valid_o), 32'(e_valid));
    chk(addr_err_o === e_err, req, 32'(addr_err_o), 32'(e_err));
    if (known) chk(rdata_o === e_data, req, 32'(rdata_o), 32'(e_data));
  endtask

  task automatic wr(input int a, input logic [WIDTH-1:0] d, input string req);
    step(1'b0, 1'b0, a, d, 1'b1, req);
  endtask
  task automatic rd(input int a, input string req);
    step(1'b0, 1'b1, a, '0, 1'b1, req);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk(valid_o === 1'b0, "R1", 32'(valid_o), 0);
    chk(addr_err_o === 1'b0, "R1", 32'(addr_err_o), 0);
    chk(rdata_o === '0, "R1", 32'(rdata_o), 0);
    rst_ni = 1'b1;
    step(1'b1, 1'b1, 0, '0, 1'b1, "R1");

    // R4/R5: basic write then read at several addresses
    wr(0, 16'h1234, "R4"); wr(5, 16'hA5A5, "R4"); wr(99, 16'hFFFF, "R4"); wr(63, 16'h0001, "R4");
    rd(0, "R5"); rd(99, "R5"); rd(5, "R5"); rd(63, "R5");
    for (int i = 10; i < 30; i++) wr(i, WIDTH'(i * 16'h0F1D + 3), "R4");
    for (int i = 29; i >= 10; i--) rd(i, "R5");

    // R8: back-to-back write then read, including overwrite
    wr(7, 16'h5A5A, "R8"); rd(7, "R8");
    wr(7, 16'hC3C3, "R8"); rd(7, "R8");

    // R2: inputs changed between edges do not reach the outputs
    rd(5, "R2");
    begin
      logic [WIDTH-1:0] hold_d;
      logic hold_v;
      hold_d = rdata_o; hold_v = valid_o;
      addr_i = AW'(99); cs_ni = 1'b1; we_ni = 1'b0; wdata_i = 16'h0BAD;
      #3;
      chk(rdata_o === hold_d, "R2", 32'(rdata_o), 32'(hold_d));
      chk(valid_o === hold_v, "R2", 32'(valid_o), 32'(hold_v));
    end

    // R3: deselected cycle with write enable low writes nothing
    step(1'b1, 1'b0, 5, 16'hDEAD, 1'b1, "R3");
    step(1'b1, 1'b1, 0, '0, 1'b1, "R3");
    rd(5, "R3");

    // R6: out-of-range accesses flag an error and write nothing
    wr(100, 16'hBEEF, "R6"); rd(127, "R6"); wr(127, 16'h7777, "R6");
    rd(0, "R6"); rd(63, "R6"); rd(99, "R6");

    // R7: forced disable blocks output and write
    step(1'b0, 1'b1, 5, '0, 1'b0, "R7");
    step(1'b0, 1'b0, 5, 16'h4321, 1'b0, "R7");
    step(1'b1, 1'b1, 0, '0, 1'b0, "R7");
    rd(5, "R7");

    // R4/R5 mixed pattern after disturbances
    wr(98, 16'h8001, "R4"); rd(98, "R5"); rd(7, "R5"); rd(10, "R5");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule